// File: doc/BRIEF.md
# Posit Precision Converter

This block moves posit values between a narrow and a wide storage width. Every width uses the same 2-bit exponent field, so the regime, exponent and fraction keep their relative places in the bit string. Because of that, neither direction has to split the value into its fields.

The widening path appends zeros to the right of the narrow pattern. It is combinational, so the wide result appears in the same cycle as its input.

The narrowing path works on the magnitude of the two's-complement pattern. It drops the low bits and rounds to nearest, ties to even. Two clamps apply: a nonzero value never becomes zero, and it never becomes the not-a-real code. The rounded result is registered and shows up one cycle after its qualifying valid strobe. Zero and not-a-real pass through unchanged in both directions.

Top module: `posit_prec_cvt`

## Requirements
- R1: `wide_o` equals `narrow_in_i` followed by `WIDE_W-NARROW_W` zero bits, in the same cycle with no register.
- R2: After reset, `valid_o` is 0 and `narrow_o` is 0. A result appears on `narrow_o` with `valid_o`=1 exactly one clock after `valid_i`=1 is sampled, and `valid_o` is 0 in the cycle after `valid_i`=0.
- R3: When all dropped low bits of a positive input are zero, `narrow_o` equals the top `NARROW_W` bits of `wide_in_i`.
- R4: A positive input rounds to nearest, ties to even. The guard bit is the highest dropped bit and the sticky bit is the OR of the remaining dropped bits. The kept part is incremented when guard=1 and either sticky=1 or the kept LSB=1.
- R5: A negative input (MSB 1, other bits not all zero) is rounded as its two's-complement magnitude under R3/R4/R6/R7, and the result is negated, so the output sign bit equals the input sign bit.
- R6: A magnitude that would round past maxpos (0 followed by all ones) yields maxpos, or its negation (1 followed by zeros and a final 1) for negative inputs. It never yields not-a-real.
- R7: A nonzero magnitude whose rounded kept part would be zero yields minpos (all zeros and a final 1), or all ones for negative inputs.
- R8: Zero (all bits 0) maps to zero and not-a-real (1 followed by all zeros) maps to not-a-real, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| narrow_in_i | input | NARROW_W | Narrow posit to widen |
| wide_o | output | WIDE_W | Widened posit, combinational |
| wide_in_i | input | WIDE_W | Wide posit to narrow |
| valid_i | input | 1 | Qualifies `wide_in_i` |
| narrow_o | output | NARROW_W | Rounded narrow posit, registered |
| valid_o | output | 1 | Qualifies `narrow_o` |

## Verification
The bench targets the exact halfway cases on both kept-LSB parities. A design that rounded ties away from zero, or that ignored sticky, would come out one code off. It pushes magnitudes just above maxpos: a plain adder would wrap these into not-a-real. It also pushes tiny nonzero values, which a plain truncation would flush to zero. Negative counterparts of each case are sent too, so rounding the raw two's-complement bits instead of the magnitude would show up as an asymmetric result. Zero and not-a-real are sent through both paths, together with the valid timing around idle cycles.

// File: rtl/posit_cvt_pkg.sv
package posit_cvt_pkg;
  typedef enum logic [1:0] {
    RND_KEEP,
    RND_INC,
    RND_SAT_MAX,
    RND_SAT_MIN
  } rnd_act_e;
endpackage

// File: rtl/posit_widen.sv
module posit_widen #(
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned WIDE_W   = 32
) (
  input  logic [NARROW_W-1:0] narrow_i,
  output logic [WIDE_W-1:0]   wide_o
);
  localparam int unsigned PAD_W = WIDE_W - NARROW_W;

  assign wide_o = {narrow_i, {PAD_W{1'b0}}};
endmodule

// File: rtl/posit_narrow_round.sv
module posit_narrow_round
  import posit_cvt_pkg::*;
#(
  parameter int unsigned WIDE_W   = 32,
  parameter int unsigned NARROW_W = 16
) (
  input  logic [WIDE_W-1:0]   wide_i,
  output logic [NARROW_W-1:0] narrow_o
);
  localparam int unsigned DROP_W = WIDE_W - NARROW_W;
  localparam logic [WIDE_W-1:0]   STICKY_MASK = {WIDE_W{1'b1}} >> (NARROW_W + 1);
  localparam logic [WIDE_W-1:0]   NAR_W_PAT   = {1'b1, {(WIDE_W-1){1'b0}}};
  localparam logic [NARROW_W-1:0] NAR_N_PAT   = {1'b1, {(NARROW_W-1){1'b0}}};
  localparam logic [NARROW_W-1:0] MAXPOS_N    = {1'b0, {(NARROW_W-1){1'b1}}};
  localparam logic [NARROW_W-1:0] MINPOS_N    = {{(NARROW_W-1){1'b0}}, 1'b1};

  logic                sgn, is_zero, is_nar, guard, sticky, inc;
  logic [WIDE_W-1:0]   mag;
  logic [NARROW_W-1:0] kept, bumped, mag_n;
  rnd_act_e            act;

  assign sgn     = wide_i[WIDE_W-1];
  assign is_zero = (wide_i == '0);
  assign is_nar  = (wide_i == NAR_W_PAT);
  assign mag     = sgn ? ({WIDE_W{1'b0}} - wide_i) : wide_i;

  // kept part includes the (always zero) sign position of the magnitude
  assign kept   = mag[WIDE_W-1:DROP_W];
  assign guard  = mag[DROP_W-1];
  assign sticky = |(mag & STICKY_MASK);
  assign inc    = guard & (sticky | kept[0]);
  assign bumped = kept + {{(NARROW_W-1){1'b0}}, inc};

  always_comb begin
    if (kept == MAXPOS_N && inc) act = RND_SAT_MAX;
    else if (bumped == '0)       act = RND_SAT_MIN;
    else if (inc)                act = RND_INC;
    else                         act = RND_KEEP;
  end

  always_comb begin
    unique case (act)
      RND_SAT_MAX: mag_n = MAXPOS_N;
      RND_SAT_MIN: mag_n = MINPOS_N;
      RND_INC:     mag_n = bumped;
      default:     mag_n = kept;
    endcase
  end

  always_comb begin
    if (is_zero)     narrow_o = '0;
    else if (is_nar) narrow_o = NAR_N_PAT;
    else if (sgn)    narrow_o = {NARROW_W{1'b0}} - mag_n;
    else             narrow_o = mag_n;
  end
endmodule

// File: rtl/posit_prec_cvt.sv
module posit_prec_cvt #(
  parameter int unsigned WIDE_W   = 32,
  parameter int unsigned NARROW_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NARROW_W-1:0] narrow_in_i,
  output logic [WIDE_W-1:0]   wide_o,
  input  logic [WIDE_W-1:0]   wide_in_i,
  input  logic                valid_i,
  output logic [NARROW_W-1:0] narrow_o,
  output logic                valid_o
);
  localparam int unsigned PAD_W = WIDE_W - NARROW_W;
  localparam logic [WIDE_W-1:0]   NAR_W_PAT = {1'b1, {(WIDE_W-1){1'b0}}};
  localparam logic [NARROW_W-1:0] NAR_N_PAT = {1'b1, {(NARROW_W-1){1'b0}}};

  logic [NARROW_W-1:0] rounded;

  posit_widen #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_widen (
    .narrow_i (narrow_in_i),
    .wide_o   (wide_o)
  );

  posit_narrow_round #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_round (
    .wide_i   (wide_in_i),
    .narrow_o (rounded)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      narrow_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) narrow_o <= rounded;
    end
  end

  AST_WIDEN_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wide_o[WIDE_W-1 -: NARROW_W] == narrow_in_i && wide_o[PAD_W-1:0] == '0); // R1
  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2
  AST_IDLE_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R2
  AST_SIGN_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && wide_in_i != '0 |=> narrow_o[NARROW_W-1] == $past(wide_in_i[WIDE_W-1])); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && wide_in_i != NAR_W_PAT |=> narrow_o != NAR_N_PAT); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && wide_in_i != '0 |=> narrow_o != '0); // R7
  AST_ZERO_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && wide_in_i == '0 |=> narrow_o == '0); // R8
  AST_NAR_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && wide_in_i == NAR_W_PAT |=> narrow_o == NAR_N_PAT); // R8
  AST_NAR_WIDEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    narrow_in_i == NAR_N_PAT |-> wide_o == NAR_W_PAT); // R8
endmodule

// File: tb/posit_prec_cvt_tb.sv
module posit_prec_cvt_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] narrow_in = '0;
  logic [31:0] wide_o;
  logic [31:0] wide_in = '0;
  logic        valid_in = 1'b0;
  logic [15:0] narrow_o;
  logic        valid_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  posit_prec_cvt #(.WIDE_W(32), .NARROW_W(16)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .narrow_in_i(narrow_in), .wide_o(wide_o),
    .wide_in_i(wide_in), .valid_i(valid_in),
    .narrow_o(narrow_o), .valid_o(valid_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // driver: one narrowing item per cycle, expected value to the scoreboard
  task automatic drive_narrow(input logic [31:0] x, input logic [15:0] exp, input string tag);
    wide_in  = x;
    valid_in = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    valid_in = 1'b0;
  endtask

  task automatic check_widen(input logic [15:0] x, input logic [31:0] exp, input string tag);
    narrow_in = x;
    #1;
    chk(wide_o == exp, tag, wide_o, exp);
  endtask

  // monitor
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected valid_o", 32'(valid_o), 32'd0);
        end else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(narrow_o == e, t, 32'(narrow_o), 32'(e));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #1;
    chk(valid_o == 1'b0, "R2 reset valid_o", 32'(valid_o), 32'd0);
    chk(narrow_o == 16'h0, "R2 reset narrow_o", 32'(narrow_o), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check_widen(16'h1234, 32'h1234_0000, "R1 widen plain");
    check_widen(16'hFFFF, 32'hFFFF_0000, "R1 widen negative");
    check_widen(16'h0000, 32'h0000_0000, "R8 widen zero");
    check_widen(16'h8000, 32'h8000_0000, "R8 widen NaR");

    @(negedge clk);
    drive_narrow(32'h1234_0000, 16'h1234, "R3 exact");
    drive_narrow(32'h1234_8000, 16'h1234, "R4 tie even stays");
    drive_narrow(32'h1235_8000, 16'h1236, "R4 tie odd rounds up");
    drive_narrow(32'h1234_8001, 16'h1235, "R4 above half");
    drive_narrow(32'h1234_7FFF, 16'h1234, "R4 below half");
    drive_narrow(32'hEDCC_0000, 16'hEDCC, "R5 negative exact");
    drive_narrow(32'hEDCA_8000, 16'hEDCA, "R5 negative tie odd");
    drive_narrow(32'h7FFF_C000, 16'h7FFF, "R6 clamp maxpos");
    drive_narrow(32'h8000_4000, 16'h8001, "R6 clamp neg maxpos");
    drive_narrow(32'h0000_8000, 16'h0001, "R7 tie to zero clamps minpos");
    drive_narrow(32'h0000_0001, 16'h0001, "R7 tiny clamps minpos");
    drive_narrow(32'hFFFF_FFFF, 16'hFFFF, "R7 neg tiny clamps");
    drive_narrow(32'h0001_8000, 16'h0002, "R4 minpos tie odd");
    drive_narrow(32'h0000_0000, 16'h0000, "R8 narrow zero");
    drive_narrow(32'h8000_0000, 16'h8000, "R8 narrow NaR");

    // idle cycle: no valid_o, output holds the last result
    @(negedge clk);
    chk(valid_o == 1'b0, "R2 idle valid_o low", 32'(valid_o), 32'd0);
    chk(narrow_o == 16'h8000, "R2 idle holds output", 32'(narrow_o), 32'h8000);

    drive_narrow(32'h4000_0000, 16'h4000, "R3 one after idle");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 scoreboard drained", 32'(exp_q.size()), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule